// File: doc/BRIEF.md
# Machine CSR access unit

This block holds the machine-level control and status registers of a small 32-bit RISC-V core that runs one instruction at a time. The decode stage hands it one operation: a three-bit function code taken from the instruction, separate read and write flags, a 12-bit register address, an operand and the current privilege level. The unit returns the old register value one cycle later. When the operation writes, the unit finishes the read-modify-write in the background over two more cycles. Because the pipeline cannot issue another register instruction sooner than that, the unit runs alongside it without stalling.

Only a few registers exist as storage: status, trap vector, scratch, exception PC and cause. The ISA word and the implementation and hart identifiers are fixed values. A free-running clock counter and a retired-instruction counter are both 64 bits wide. Every other address reads as zero. Permission is checked from the address bits alone. A faulting operation raises a one-cycle fault pulse and changes no register. The status register and its global interrupt-enable bit are driven out at all times for the control logic.

Top module: `csr_access_unit`

## Requirements
- R1: One clock edge after an accepted operation with the read flag set and no fault, `rd_data_o` holds the value the addressed register had at that edge. Addresses and values: 0x300 status, 0x301 ISA word (default 0x40000100), 0x305 trap vector, 0x340 scratch, 0x341 exception PC, 0x342 cause, 0xF13 implementation id (default 1), 0xF14 hart id (default 0). The counters read at 0xB00/0xC00 (clock, low), 0xB80/0xC80 (clock, high), 0xB02/0xC02 (retired, low) and 0xB82/0xC82 (retired, high). Every other address reads 0.
- R2: An accepted operation with the read flag clear and no fault leaves `rd_data_o` unchanged.
- R3: An operation that writes to an address whose bits [11:10] are 2'b11 raises `access_fault_o` on the next edge and changes no register.
- R4: An operation on an address whose bits [9:8] exceed `priv_i` (0 user, 1 supervisor, 3 machine) raises `access_fault_o` on the next edge, sets `rd_data_o` to 0 and changes no register.
- R5: `access_fault_o` is high only during the single cycle after the edge that accepted the faulting operation.
- R6: The function code bits [1:0] select the update: 01 replaces the register with the operand, 10 ORs the operand in, 11 clears the operand's one bits, and 00 writes nothing. Bit 2 marks the immediate forms, which use only operand bits [4:0], zero-extended.
- R7: A write accepted at edge E takes effect at edge E+2, so the new value is seen from the third edge counted from E. `mstatus_o` changes only in that case.
- R8: A set or clear with an effective operand of zero writes nothing. It raises no fault on a read-only address, as long as the privilege check passes.
- R9: Only status bits 3 (global interrupt enable, also on `irq_en_o`) and 7 (previous enable) are stored. Bits [1:0] of the trap vector and of the exception PC always read 0.
- R10: The clock counter is 0 after reset and increments on every rising edge while reset is released.
- R11: The retired counter is 0 after reset and increments on each edge at which `retire_i` is high.
- R12: During reset, `rd_data_o`, `access_fault_o`, `mstatus_o` and `irq_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| op_valid_i | input | 1 | Operation presented this cycle; ignored while a write is in progress |
| op_funct_i | input | 3 | Function code from the instruction |
| op_rd_en_i | input | 1 | Operation returns the old value |
| op_wr_en_i | input | 1 | Operation may update the register |
| op_addr_i | input | 12 | Register address |
| op_operand_i | input | 32 | Source register value or immediate |
| priv_i | input | 2 | Current privilege level |
| retire_i | input | 1 | One instruction retired this cycle |
| rd_data_o | output | 32 | Old value of the addressed register |
| access_fault_o | output | 1 | Illegal access pulse |
| mstatus_o | output | 32 | Current status register |
| irq_en_o | output | 1 | Global machine interrupt enable |

## Verification
The read value and the fault pulse are due at the first rising edge after the operation is presented. A committed write is due at the third edge. The counters change at every edge. The bench keeps a behavioural model that advances on each rising edge and applies pending writes from a countdown, so that each result appears in the model in the same cycle the requirements give for the design. It compares all outputs with the model at every falling edge, so a result that arrives one cycle early or late is reported. Directed sequences add literal checks on masked fields, zero-operand set and clear, privilege faults and the exact cycle in which a status write appears.

// File: rtl/csr_pkg.sv
package csr_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'b00,
    ACT_WRITE = 2'b01,
    ACT_SET   = 2'b10,
    ACT_CLEAR = 2'b11
  } csr_act_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_MODIFY = 2'b01,
    ST_COMMIT = 2'b10
  } csr_state_e;

  localparam logic [11:0] A_MSTATUS  = 12'h300;
  localparam logic [11:0] A_MISA     = 12'h301;
  localparam logic [11:0] A_MTVEC    = 12'h305;
  localparam logic [11:0] A_MSCRATCH = 12'h340;
  localparam logic [11:0] A_MEPC     = 12'h341;
  localparam logic [11:0] A_MCAUSE   = 12'h342;
  localparam logic [11:0] A_IMPL     = 12'hF13;
  localparam logic [11:0] A_HART     = 12'hF14;

  localparam logic [31:0] STATUS_KEEP = 32'h0000_0088;
  localparam logic [31:0] ALIGN_KEEP  = 32'hFFFF_FFFC;
endpackage

// File: rtl/csr_access_check.sv
module csr_access_check #(
  parameter int AW = 12
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    priv_i,
  input  logic          wr_i,
  output logic          fault_o
);
  logic read_only;
  logic too_low;

  // top two address bits 11 mark a read-only register
  assign read_only = (addr_i[AW-1:AW-2] == 2'b11);
  // next two bits give the least privilege allowed
  assign too_low   = (priv_i < addr_i[AW-3:AW-4]);
  assign fault_o   = too_low | (read_only & wr_i);
endmodule

// File: rtl/csr_event_counter.sv
module csr_event_counter #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/csr_rmw_fsm.sv
module csr_rmw_fsm
  import csr_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  csr_act_e      act_i,
  input  logic [DW-1:0] old_i,
  input  logic [DW-1:0] opnd_i,
  input  logic [AW-1:0] addr_i,
  output logic          busy_o,
  output logic          wr_stb_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_val_o
);
  csr_state_e    state_q, state_d;
  csr_act_e      act_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] old_q, opnd_q, val_q, val_d;
  logic          ld_op, ld_val;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_MODIFY;
      ST_MODIFY: state_d = ST_COMMIT;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (act_q)
      ACT_WRITE: val_d = opnd_q;
      ACT_SET:   val_d = old_q | opnd_q;
      ACT_CLEAR: val_d = old_q & ~opnd_q;
      default:   val_d = old_q;
    endcase
  end

  assign ld_op  = (state_q == ST_IDLE) & start_i;
  assign ld_val = (state_q == ST_MODIFY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= ACT_NONE;
      addr_q <= '0;
      old_q  <= '0;
      opnd_q <= '0;
    end else if (ld_op) begin
      act_q  <= act_i;
      addr_q <= addr_i;
      old_q  <= old_i;
      opnd_q <= opnd_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (ld_val) val_q <= val_d;
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign wr_stb_o  = (state_q == ST_COMMIT);
  assign wr_addr_o = addr_q;
  assign wr_val_o  = val_q;
endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
  import csr_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          CNT_W    = 64,
  parameter int          HART_ID  = 0,
  parameter logic [31:0] IMPL_ID  = 32'h0000_0001,
  parameter logic [31:0] MISA_VAL = 32'h4000_0100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            op_valid_i,
  input  logic [2:0]      op_funct_i,
  input  logic            op_rd_en_i,
  input  logic            op_wr_en_i,
  input  logic [11:0]     op_addr_i,
  input  logic [XLEN-1:0] op_operand_i,
  input  logic [1:0]      priv_i,
  input  logic            retire_i,
  output logic [XLEN-1:0] rd_data_o,
  output logic            access_fault_o,
  output logic [XLEN-1:0] mstatus_o,
  output logic            irq_en_o
);
  localparam int AW    = 12;
  localparam int CNT_N = 2;
  localparam int ZIMM  = 5;

  csr_act_e        act;
  logic            fsm_busy, accept, fault, eff_wr, setclr, start, wr_stb;
  logic [XLEN-1:0] opnd, rd_val, wr_val, rd_q;
  logic [AW-1:0]   wr_addr;
  logic            fault_q;
  logic [XLEN-1:0] mstatus_q, mtvec_q, mscratch_q, mepc_q, mcause_q;
  logic [CNT_N-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_val [CNT_N];
  logic [63:0]     cnt_wide;
  logic            ctr_hit;

  // operation decode
  assign act    = csr_act_e'(op_funct_i[1:0]);
  assign opnd   = op_funct_i[2] ? XLEN'(op_operand_i[ZIMM-1:0]) : op_operand_i;
  assign setclr = (act == ACT_SET) || (act == ACT_CLEAR);
  assign eff_wr = op_wr_en_i && (act != ACT_NONE) && !(setclr && (opnd == '0));
  assign accept = op_valid_i && !fsm_busy;
  assign start  = accept && eff_wr && !fault;

  csr_access_check #(.AW(AW)) u_check (
    .addr_i  (op_addr_i),
    .priv_i  (priv_i),
    .wr_i    (eff_wr),
    .fault_o (fault)
  );

  // index 0 counts clocks, index 1 counts retired instructions
  assign cnt_inc = {retire_i, 1'b1};
  for (genvar g = 0; g < CNT_N; g++) begin : g_cnt
    csr_event_counter #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (cnt_inc[g]),
      .cnt_o  (cnt_val[g])
    );
  end

  assign cnt_wide = 64'(cnt_val[op_addr_i[1]]);
  assign ctr_hit  = ((op_addr_i[11:8] == 4'hB) || (op_addr_i[11:8] == 4'hC)) &&
                    (op_addr_i[6:2] == 5'd0) && !op_addr_i[0];

  always_comb begin
    case (op_addr_i)
      A_MSTATUS:  rd_val = mstatus_q;
      A_MISA:     rd_val = XLEN'(MISA_VAL);
      A_MTVEC:    rd_val = mtvec_q;
      A_MSCRATCH: rd_val = mscratch_q;
      A_MEPC:     rd_val = mepc_q;
      A_MCAUSE:   rd_val = mcause_q;
      A_IMPL:     rd_val = XLEN'(IMPL_ID);
      A_HART:     rd_val = XLEN'(HART_ID);
      default:    rd_val = !ctr_hit     ? '0 :
                           op_addr_i[7] ? XLEN'(cnt_wide[63:32]) : XLEN'(cnt_wide[31:0]);
    endcase
  end

  csr_rmw_fsm #(.DW(XLEN), .AW(AW)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .act_i     (act),
    .old_i     (rd_val),
    .opnd_i    (opnd),
    .addr_i    (op_addr_i),
    .busy_o    (fsm_busy),
    .wr_stb_o  (wr_stb),
    .wr_addr_o (wr_addr),
    .wr_val_o  (wr_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= accept & fault;
      if (accept && (fault || op_rd_en_i)) rd_q <= fault ? '0 : rd_val;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mstatus_q  <= '0;
      mtvec_q    <= '0;
      mscratch_q <= '0;
      mepc_q     <= '0;
      mcause_q   <= '0;
    end else if (wr_stb) begin
      case (wr_addr)
        A_MSTATUS:  mstatus_q  <= wr_val & XLEN'(STATUS_KEEP);
        A_MTVEC:    mtvec_q    <= wr_val & XLEN'(ALIGN_KEEP);
        A_MSCRATCH: mscratch_q <= wr_val;
        A_MEPC:     mepc_q     <= wr_val & XLEN'(ALIGN_KEEP);
        A_MCAUSE:   mcause_q   <= wr_val;
        default:    ;
      endcase
    end
  end

  assign rd_data_o      = rd_q;
  assign access_fault_o = fault_q;
  assign mstatus_o      = mstatus_q;
  assign irq_en_o       = mstatus_q[3];
endmodule

// File: rtl/csr_access_unit_chk.sv
module csr_access_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            op_valid_i,
  input logic [2:0]      op_funct_i,
  input logic            op_wr_en_i,
  input logic [11:0]     op_addr_i,
  input logic [1:0]      priv_i,
  input logic [XLEN-1:0] rd_data_o,
  input logic            access_fault_o,
  input logic [XLEN-1:0] mstatus_o,
  input logic            busy_i
);
  // R3
  ro_write_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !busy_i && op_wr_en_i &&
     (op_funct_i == 3'b001 || op_funct_i == 3'b101) && op_addr_i[11:10] == 2'b11)
    |=> access_fault_o);

  // R4
  low_priv_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !busy_i && (priv_i < op_addr_i[9:8])) |=> access_fault_o);

  // R5
  fault_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_fault_o |-> $past(op_valid_i));

  // R2
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(op_valid_i) |-> $stable(rd_data_o));

  // R7
  status_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mstatus_o) |-> $past(op_valid_i, 3));

  // R9
  status_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mstatus_o & ~32'h0000_0088) == '0);
endmodule

bind csr_access_unit csr_access_unit_chk #(.XLEN(XLEN)) u_chk (.*, .busy_i(fsm_busy));

// File: tb/test_csr_access_unit.sv
`timescale 1ns/1ps
module test_csr_access_unit;
  localparam time TCK = 4ns;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        op_valid_i, op_rd_en_i, op_wr_en_i, retire_i;
  logic [2:0]  op_funct_i;
  logic [11:0] op_addr_i;
  logic [31:0] op_operand_i;
  logic [1:0]  priv_i;
  logic [31:0] rd_data_o, mstatus_o;
  logic        access_fault_o, irq_en_o;

  int    n_chk = 0, n_fail = 0;
  string cur_tag = "R12";
  bit    running = 1'b0;

  csr_access_unit i_csr_access_unit (.*);

  always #(TCK/2) clk_i = ~clk_i;

  // ---------------- reference model ----------------
  logic [31:0] m_status, m_tvec, m_scratch, m_epc, m_cause, m_rd;
  logic        m_fault;
  logic [63:0] m_cyc, m_ins;
  int          p_cnt;
  logic [11:0] p_addr;
  logic [31:0] p_val;

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      12'h300: return m_status;
      12'h301: return 32'h4000_0100;
      12'h305: return m_tvec;
      12'h340: return m_scratch;
      12'h341: return m_epc;
      12'h342: return m_cause;
      12'hF13: return 32'h1;
      12'hB00, 12'hC00: return m_cyc[31:0];
      12'hB80, 12'hC80: return m_cyc[63:32];
      12'hB02, 12'hC02: return m_ins[31:0];
      12'hB82, 12'hC82: return m_ins[63:32];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_status = 0; m_tvec = 0; m_scratch = 0; m_epc = 0; m_cause = 0;
      m_rd = 0; m_fault = 0; m_cyc = 0; m_ins = 0; p_cnt = 0;
    end else begin
      logic [31:0] v;
      logic        w, f;
      if (p_cnt > 0) begin
        p_cnt--;
        if (p_cnt == 0) begin
          case (p_addr)
            12'h300: m_status  = p_val & 32'h88;
            12'h305: m_tvec    = p_val & ~32'h3;
            12'h340: m_scratch = p_val;
            12'h341: m_epc     = p_val & ~32'h3;
            12'h342: m_cause   = p_val;
            default: ;
          endcase
        end
      end
      m_fault = 1'b0;
      if (op_valid_i) begin
        v = op_funct_i[2] ? {27'd0, op_operand_i[4:0]} : op_operand_i;
        w = op_wr_en_i && op_funct_i[1:0] != 2'b00 &&
            !(op_funct_i[1] && v == 0);
        f = (priv_i < op_addr_i[9:8]) || (w && op_addr_i[11:10] == 2'b11);
        m_fault = f;
        if (f) m_rd = 0;
        else if (op_rd_en_i) m_rd = m_read(op_addr_i);
        if (w && !f) begin
          p_addr = op_addr_i;
          p_cnt  = 2;
          case (op_funct_i[1:0])
            2'b01:   p_val = v;
            2'b10:   p_val = m_read(op_addr_i) | v;
            default: p_val = m_read(op_addr_i) & ~v;
          endcase
        end
      end
      m_cyc++;
      if (retire_i) m_ins++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk_i) begin
    if (running && rst_ni) begin
      check(rd_data_o === m_rd, cur_tag, rd_data_o, m_rd);
      check(access_fault_o === m_fault, "R3/R4/R5 fault", {31'd0, access_fault_o}, {31'd0, m_fault});
      check(mstatus_o === m_status, "R7/R9 status", mstatus_o, m_status);
      check(irq_en_o === m_status[3], "R9 irq_en", {31'd0, irq_en_o}, {31'd0, m_status[3]});
    end
  end

  // retire pulses: high one cycle in three
  initial begin
    retire_i = 1'b0;
    for (int k = 0; ; k++) begin
      @(negedge clk_i);
      retire_i = (k % 3 == 1);
    end
  end

  task automatic do_op(input logic [2:0] f, input logic rd, input logic wr,
                       input logic [11:0] a, input logic [31:0] v,
                       input logic [1:0] p, input string tag);
    cur_tag      = tag;
    op_funct_i   = f;
    op_rd_en_i   = rd;
    op_wr_en_i   = wr;
    op_addr_i    = a;
    op_operand_i = v;
    priv_i       = p;
    op_valid_i   = 1'b1;
    @(negedge clk_i);
    op_valid_i   = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic expect_rd(input logic [31:0] exp, input string tag);
    check(rd_data_o === exp, tag, rd_data_o, exp);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; op_valid_i = 1'b0; op_funct_i = 3'b000; op_rd_en_i = 1'b0;
    op_wr_en_i = 1'b0; op_addr_i = '0; op_operand_i = '0; priv_i = 2'd3;
    repeat (3) @(negedge clk_i);
    // R12 reset state
    check(rd_data_o === 0, "R12 rd_data", rd_data_o, 0);
    check(access_fault_o === 0, "R12 fault", {31'd0, access_fault_o}, 0);
    check(mstatus_o === 0, "R12 status", mstatus_o, 0);
    check(irq_en_o === 0, "R12 irq_en", {31'd0, irq_en_o}, 0);
    rst_ni = 1'b1;
    running = 1'b1;
    repeat (2) @(negedge clk_i);

    // R1 fixed values and unimplemented space
    do_op(3'b010, 1, 0, 12'h301, 0, 3, "R1 isa");      expect_rd(32'h4000_0100, "R1 isa literal");
    do_op(3'b010, 1, 0, 12'hF13, 0, 3, "R1 impl");     expect_rd(32'h1, "R1 impl literal");
    do_op(3'b010, 1, 0, 12'hF14, 0, 3, "R1 hart");     expect_rd(32'h0, "R1 hart literal");
    do_op(3'b010, 1, 0, 12'h7C0, 0, 3, "R1 unimpl");   expect_rd(32'h0, "R1 unimpl literal");

    // R6 update kinds on the scratch register
    do_op(3'b001, 1, 1, 12'h340, 32'hA5A5_0F0F, 3, "R6 rw");
    do_op(3'b010, 1, 0, 12'h340, 0, 3, "R6 read");     expect_rd(32'hA5A5_0F0F, "R6 rw literal");
    do_op(3'b010, 1, 1, 12'h340, 32'h0000_F000, 3, "R6 set");
    do_op(3'b010, 1, 0, 12'h340, 0, 3, "R6 read");     expect_rd(32'hA5A5_FF0F, "R6 set literal");
    do_op(3'b011, 1, 1, 12'h340, 32'hA500_0000, 3, "R6 clear");
    do_op(3'b010, 1, 0, 12'h340, 0, 3, "R6 read");     expect_rd(32'h00A5_FF0F, "R6 clear literal");
    do_op(3'b101, 1, 1, 12'h340, 32'hFFFF_FFF3, 3, "R6 rwi");
    do_op(3'b010, 1, 0, 12'h340, 0, 3, "R6 read");     expect_rd(32'h0000_0013, "R6 imm literal");
    do_op(3'b110, 1, 1, 12'h340, 32'h0000_0004, 3, "R6 seti");
    do_op(3'b111, 1, 1, 12'h340, 32'h0000_0001, 3, "R6 clri");
    do_op(3'b010, 1, 0, 12'h340, 0, 3, "R6 read");     expect_rd(32'h0000_0016, "R6 imm set/clear literal");

    // R9 masked fields
    do_op(3'b001, 1, 1, 12'h305, 32'h1234_5677, 3, "R9 tvec");
    do_op(3'b010, 1, 0, 12'h305, 0, 3, "R9 read");     expect_rd(32'h1234_5674, "R9 tvec literal");
    do_op(3'b001, 1, 1, 12'h341, 32'hFFFF_FFFF, 3, "R9 epc");
    do_op(3'b010, 1, 0, 12'h341, 0, 3, "R9 read");     expect_rd(32'hFFFF_FFFC, "R9 epc literal");
    do_op(3'b001, 1, 1, 12'h300, 32'hFFFF_FFFF, 3, "R9 status");
    check(mstatus_o === 32'h88, "R9 status literal", mstatus_o, 32'h88);
    do_op(3'b001, 1, 1, 12'h342, 32'h8000_000B, 3, "R1 cause");
    do_op(3'b010, 1, 0, 12'h342, 0, 3, "R1 read");     expect_rd(32'h8000_000B, "R1 cause literal");

    // R7 exact write timing on the status output
    cur_tag = "R7 timing";
    op_funct_i = 3'b011; op_rd_en_i = 1; op_wr_en_i = 1; op_addr_i = 12'h300;
    op_operand_i = 32'h80; priv_i = 3; op_valid_i = 1'b1;
    @(negedge clk_i); op_valid_i = 1'b0;
    check(mstatus_o === 32'h88, "R7 after edge 1", mstatus_o, 32'h88);
    @(negedge clk_i);
    check(mstatus_o === 32'h88, "R7 after edge 2", mstatus_o, 32'h88);
    @(negedge clk_i);
    check(mstatus_o === 32'h08, "R7 after edge 3", mstatus_o, 32'h08);
    repeat (3) @(negedge clk_i);

    // R2 read flag clear keeps the previous result
    do_op(3'b010, 1, 0, 12'h301, 0, 3, "R2 prime");
    do_op(3'b001, 0, 1, 12'h340, 32'h0BAD_F00D, 3, "R2 no read");
    expect_rd(32'h4000_0100, "R2 held literal");

    // R8 zero operand suppresses the write
    do_op(3'b010, 1, 1, 12'hC00, 0, 3, "R8 set zero ro");
    check(access_fault_o === 0, "R8 no fault", {31'd0, access_fault_o}, 0);
    do_op(3'b111, 1, 1, 12'h340, 32'hFFFF_FFE0, 3, "R8 clri zero");
    do_op(3'b010, 1, 0, 12'h340, 0, 3, "R8 read");     expect_rd(32'h0BAD_F00D, "R8 unchanged literal");

    // R3 and R5 writes to read-only space
    do_op(3'b001, 1, 1, 12'hF14, 32'h5, 3, "R3 write ro");
    check(access_fault_o === 0, "R5 pulse ended", {31'd0, access_fault_o}, 0);
    do_op(3'b010, 1, 0, 12'hF14, 0, 3, "R3 read");     expect_rd(32'h0, "R3 hart unchanged");
    do_op(3'b011, 1, 1, 12'hC02, 32'h1, 3, "R3 clear ro counter");

    // R4 privilege
    do_op(3'b010, 1, 0, 12'h300, 0, 0, "R4 user status");
    do_op(3'b010, 1, 0, 12'hC00, 0, 0, "R4 user cycle");
    do_op(3'b001, 1, 1, 12'h305, 32'h100, 1, "R4 sup tvec");
    do_op(3'b010, 1, 0, 12'h305, 0, 3, "R4 read");     expect_rd(32'h1234_5674, "R4 tvec unchanged");
    do_op(3'b010, 1, 0, 12'h100, 0, 1, "R4 sup ok");

    // R10 and R11 counters
    for (int i = 0; i < 6; i++) begin
      do_op(3'b010, 1, 0, 12'hC00, 0, 3, "R10 cycle lo");
      do_op(3'b010, 1, 0, 12'hB80, 0, 3, "R10 cycle hi");
      do_op(3'b010, 1, 0, 12'hB02, 0, 3, "R11 retired lo");
      do_op(3'b010, 1, 0, 12'hC82, 0, 3, "R11 retired hi");
    end

    repeat (4) @(negedge clk_i);
    running = 1'b0;
    finish_run();
  end
endmodule